// File: doc/BRIEF.md
# Power-On Reset Timing Sequencer

This block keeps a processor core in reset until both its supply and its clock can be trusted. It merges three reset sources into one request: a power-on pulse, an external active-low reset pin with a glitch filter, and a software reset strobe. Once every request has gone away, the block runs a chain of waits. The first wait is a power-up timer counted on the internal RC clock. The second is an oscillator start-up count taken on the external oscillator clock. The last is an optional PLL lock wait, counted again on the internal clock. When the chain ends, the core reset is released and the clock-ready flag goes high.

Each later stage runs only in some oscillator modes and only after some reset causes. The oscillator start-up count is used only for crystal and resonator modes, and only when the sequence was started by a power-on. The PLL wait is used only in the crystal-plus-PLL mode. A sticky active-low power-on flag records that a power-on took place. Software can set it back to 1, and no other reset touches it. The power-on input also serves as the block's synchronous active-high reset on the internal clock.

Top module: `por_sequencer`

## Requirements
- R1: While `por_in` is high, `core_rst` is 1, `clk_ready` is 0 and `por_flag_n` is 0. After `por_in` falls, the sequence starts from its first stage.
- R2: The power-up timer is enabled when `pwrt_en_n` is 0. It holds reset for 2^PWRT_BITS internal ticks. When `pwrt_en_n` is 1 the stage is skipped, so a one-cycle request with no other stage keeps `core_rst` high for exactly 1 sampled cycle. With the timer alone it is high for 2^PWRT_BITS+1 sampled cycles.
- R3: After a power-on, modes 0 (LP), 1 (XT), 2 (HS) and 3 (HSPLL) add a wait of OST_CYCLES oscillator cycles after the power-up timer. The crossing into and out of the oscillator domain adds a few cycles of synchroniser delay. Modes 4 to 7 (EC, RC, internal oscillator, reserved) add no such wait.
- R4: A sequence started by the pin or by software skips the oscillator start-up wait in every mode.
- R5: In mode 3 only, a PLL lock wait of PLL_TICKS internal ticks follows the oscillator start-up wait.
- R6: When the reset pin is enabled, holding `rst_pin_n` low for at least FILT_LEN consecutive synchronised samples requests a reset. Shorter low pulses have no effect on `core_rst`.
- R7: When `pin_en` is 0, `rst_pin_n` has no effect on `core_rst` or `clk_ready`.
- R8: A one-cycle `sw_reset` pulse requests a reset, and `core_rst` is 1 in the cycle after it.
- R9: `por_flag_n` becomes 1 only through `sw_set_flag`. Pin and software resets leave it unchanged. When `por_in` and `sw_set_flag` are high in the same cycle, the flag ends at 0.
- R10: A new request arriving during any stage restarts the sequence from the power-up timer.
- R11: `clk_ready` is 1 exactly when `core_rst` has been released. It is 0 in every cycle of a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC clock; clocks the sequencer |
| clk_osc | input | 1 | External oscillator clock; clocks the start-up count |
| por_in | input | 1 | Power-on pulse, active high, synchronous to clk_rc |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| pin_en | input | 1 | 1 lets the pin cause resets |
| sw_reset | input | 1 | Software reset strobe |
| sw_set_flag | input | 1 | Software write that sets the power-on flag to 1 |
| pwrt_en_n | input | 1 | Power-up timer enable, active low |
| osc_mode | input | 3 | Oscillator mode code (0 LP, 1 XT, 2 HS, 3 HSPLL, 4 EC, 5 RC, 6 internal, 7 reserved) |
| core_rst | output | 1 | Core reset, active high, registered |
| clk_ready | output | 1 | Clock-ready status, registered |
| por_flag_n | output | 1 | Sticky power-on flag, 0 after a power-on |

## Verification
Two pairs of functions can meet in one cycle. The power-on clear and the software set of the flag are driven in the same internal clock cycle, and the flag must read 0 afterwards. A software reset is also issued part way through a running power-up timer. The bench measures how long `core_rst` stays high after the second request, and that time must equal the full timer length rather than the time left on the first run. Sequences that cross into the oscillator domain are judged against a window, because of synchroniser jitter. All purely internal-clock sequences are judged to the exact cycle.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

  // Crystal/resonator modes occupy codes 0..3; code 3 adds the PLL.
  function automatic logic mode_needs_ost(input logic [2:0] mode);
    return ~mode[2];
  endfunction

  function automatic logic mode_needs_pll(input logic [2:0] mode);
    return mode == 3'd3;
  endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/por_pin_filter.sv
module por_pin_filter #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic en,
  output logic pin_rst
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);
  localparam logic [CW-1:0] NEAR = CW'(FILT_LEN - 1);

  logic          pin_s;
  logic [CW-1:0] low_cnt;

  por_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk (clk),
    .d   (pin_n),
    .q   (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst || !en || pin_s) begin
      low_cnt <= '0;
      pin_rst <= 1'b0;
    end else begin
      if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
      pin_rst <= (low_cnt >= NEAR);
    end
  end

  // R7: a disabled pin never produces a request
  assert_pin_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pin_rst);
endmodule

// File: rtl/por_ost_timer.sv
module por_ost_timer #(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_osc,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(OST_CYCLES);
  localparam logic [CW-1:0] NEAR = CW'(OST_CYCLES - 1);

  logic          start_s;
  logic [CW-1:0] cnt;

  por_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk (clk_osc),
    .d   (start),
    .q   (start_s)
  );

  // Dropping start is the only clear this domain needs.
  always_ff @(posedge clk_osc) begin
    if (!start_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      if (cnt != FULL) cnt <= cnt + 1'b1;
      done <= (cnt >= NEAR);
    end
  end
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_seq_pkg::*;
#(
  parameter int PWRT_BITS   = 11,
  parameter int OST_CYCLES  = 1024,
  parameter int PLL_TICKS   = 64,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_rc,
  input  logic       clk_osc,
  input  logic       por_in,
  input  logic       rst_pin_n,
  input  logic       pin_en,
  input  logic       sw_reset,
  input  logic       sw_set_flag,
  input  logic       pwrt_en_n,
  input  logic [2:0] osc_mode,
  output logic       core_rst,
  output logic       clk_ready,
  output logic       por_flag_n
);
  localparam int PLL_W = $clog2(PLL_TICKS);
  localparam int TW    = (PWRT_BITS > PLL_W) ? PWRT_BITS : PLL_W;
  localparam logic [TW-1:0] PW_LAST  = TW'((1 << PWRT_BITS) - 1);
  localparam logic [TW-1:0] PLL_LAST = TW'(PLL_TICKS - 1);

  seq_state_e    state, state_d, after_pwrt;
  logic [TW-1:0] tmr;
  logic          tmr_clr;
  logic          cause_por;
  logic          pin_rst;
  logic          req;
  logic          ost_start, ost_done, ost_done_s, ost_armed;

  por_pin_filter #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk     (clk_rc),
    .rst     (por_in),
    .pin_n   (rst_pin_n),
    .en      (pin_en),
    .pin_rst (pin_rst)
  );

  por_ost_timer #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .clk_osc (clk_osc),
    .start   (ost_start),
    .done    (ost_done)
  );

  por_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk (clk_rc),
    .d   (ost_done),
    .q   (ost_done_s)
  );

  assign req = pin_rst | sw_reset;

  always_comb begin
    after_pwrt = (cause_por && mode_needs_ost(osc_mode)) ? ST_OST : ST_RUN;
    state_d    = state;
    tmr_clr    = 1'b0;
    unique case (state)
      ST_HOLD: begin
        tmr_clr = 1'b1;
        state_d = pwrt_en_n ? after_pwrt : ST_PWRT;
      end
      ST_PWRT: if (tmr == PW_LAST) begin
        tmr_clr = 1'b1;
        state_d = after_pwrt;
      end
      ST_OST: if (ost_armed && ost_done_s) begin
        tmr_clr = 1'b1;
        state_d = mode_needs_pll(osc_mode) ? ST_PLL : ST_RUN;
      end
      ST_PLL: if (tmr == PLL_LAST) begin
        tmr_clr = 1'b1;
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
    if (req) begin
      state_d = ST_HOLD;
      tmr_clr = 1'b1;
    end
  end

  always_ff @(posedge clk_rc) begin
    if (por_in) begin
      state      <= ST_HOLD;
      tmr        <= '0;
      cause_por  <= 1'b1;
      core_rst   <= 1'b1;
      clk_ready  <= 1'b0;
      por_flag_n <= 1'b0;
      ost_start  <= 1'b0;
      ost_armed  <= 1'b0;
    end else begin
      state     <= state_d;
      tmr       <= tmr_clr ? '0 : tmr + 1'b1;
      if (state_d == ST_RUN) cause_por <= 1'b0;
      core_rst  <= (state_d != ST_RUN);
      clk_ready <= (state_d == ST_RUN);
      if (sw_set_flag) por_flag_n <= 1'b1;
      ost_start <= (state_d == ST_OST);
      // Done must be seen low once before a high is trusted as this run's.
      ost_armed <= (state == ST_OST) && (ost_armed || !ost_done_s);
    end
  end

  // R8: a software request holds the core in reset next cycle
  assert_sw_holds_R8: assert property (@(posedge clk_rc) disable iff (por_in)
    sw_reset |=> core_rst);

  // R9: without a software write the flag never moves outside power-on
  assert_flag_sticky_R9: assert property (@(posedge clk_rc) disable iff (por_in)
    !sw_set_flag |=> $stable(por_flag_n));

  // R2: the power-up stage is never left early
  assert_pwrt_hold_R2: assert property (@(posedge clk_rc) disable iff (por_in)
    (state == ST_PWRT && tmr != PW_LAST && !req) |=> (state == ST_PWRT));

  // R3: the start-up stage waits for the oscillator-domain count
  assert_ost_wait_R3: assert property (@(posedge clk_rc) disable iff (por_in)
    (state == ST_OST && !ost_done_s && !req) |=> (state == ST_OST));

  // R4: the start-up stage only occurs for a power-on cause
  assert_ost_por_only_R4: assert property (@(posedge clk_rc) disable iff (por_in)
    (state == ST_OST) |-> cause_por);

  // R11: ready and reset never both report active
  assert_ready_excl_R11: assert property (@(posedge clk_rc) disable iff (por_in)
    clk_ready |-> !core_rst);
endmodule

// File: tb/tb_por_sequencer.sv
module tb_por_sequencer;
  localparam int PWRT_BITS  = 6;
  localparam int OST_CYCLES = 32;
  localparam int PLL_TICKS  = 16;
  localparam int FILT_LEN   = 4;
  localparam int RC_P  = 8;   // 125 MHz
  localparam int OSC_P = 6;
  localparam int T1    = (1 << PWRT_BITS) + 1;
  localparam int OSTRC = (OST_CYCLES * OSC_P + RC_P - 1) / RC_P;
  localparam int SLACK = 8;

  typedef struct packed {
    logic [2:0] mode;
    logic       pwrt_off;
    logic       by_por;
    int         lo;
    int         hi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 1'b0, 1'b0, T1, T1},
    '{3'd4, 1'b1, 1'b0, 1, 1},
    '{3'd2, 1'b0, 1'b0, T1, T1},
    '{3'd2, 1'b0, 1'b1, T1 + OSTRC, T1 + OSTRC + SLACK},
    '{3'd3, 1'b0, 1'b1, T1 + OSTRC + PLL_TICKS, T1 + OSTRC + PLL_TICKS + SLACK},
    '{3'd5, 1'b1, 1'b1, 1, 1},
    '{3'd1, 1'b1, 1'b1, 1 + OSTRC, 1 + OSTRC + SLACK},
    '{3'd0, 1'b0, 1'b0, T1, T1},
    '{3'd6, 1'b0, 1'b1, T1, T1}
  };
  localparam string TAGS [NV] = '{"R8", "R2", "R4", "R3", "R5", "R2", "R3", "R4", "R3"};

  logic clk_rc = 0, clk_osc = 0;
  logic por_in = 1, rst_pin_n = 1, pin_en = 1, sw_reset = 0, sw_set_flag = 0;
  logic pwrt_en_n = 0;
  logic [2:0] osc_mode = 3'd4;
  logic core_rst, clk_ready, por_flag_n;
  int checks = 0, failures = 0;

  always #(RC_P / 2) clk_rc = ~clk_rc;
  always #(OSC_P / 2) clk_osc = ~clk_osc;

  por_sequencer #(
    .PWRT_BITS(PWRT_BITS), .OST_CYCLES(OST_CYCLES), .PLL_TICKS(PLL_TICKS),
    .FILT_LEN(FILT_LEN), .SYNC_STAGES(2)
  ) dut (
    .clk_rc(clk_rc), .clk_osc(clk_osc), .por_in(por_in), .rst_pin_n(rst_pin_n),
    .pin_en(pin_en), .sw_reset(sw_reset), .sw_set_flag(sw_set_flag),
    .pwrt_en_n(pwrt_en_n), .osc_mode(osc_mode), .core_rst(core_rst),
    .clk_ready(clk_ready), .por_flag_n(por_flag_n)
  );

  task automatic chk(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Counts sampled cycles with core_rst high; also checks clk_ready stays low.
  task automatic measure(output int n, output int ready_seen);
    n = 0;
    ready_seen = 0;
    while (core_rst && n < 5000) begin
      n++;
      if (clk_ready) ready_seen = 1;
      @(negedge clk_rc);
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk_rc);
    sw_reset = 1;
    @(negedge clk_rc);
    sw_reset = 0;
  endtask

  initial begin
    #(RC_P * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, rdy, hi_seen;
    repeat (5) @(negedge clk_rc);
    // R1: state while power-on is held
    chk("R1 core_rst", int'(core_rst), 1, 1);
    chk("R1 clk_ready", int'(clk_ready), 0, 0);
    chk("R1 por_flag_n", int'(por_flag_n), 0, 0);
    por_in = 0;
    @(negedge clk_rc);
    measure(n, rdy);
    chk("R1 release time", n, T1 - 1, T1 - 1);
    chk("R11 ready after release", int'(clk_ready), 1, 1);
    chk("R11 ready low during sequence", rdy, 0, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_rc);
      osc_mode  = VECS[i].mode;
      pwrt_en_n = VECS[i].pwrt_off;
      if (VECS[i].by_por) por_in = 1; else sw_reset = 1;
      @(negedge clk_rc);
      por_in = 0;
      sw_reset = 0;
      measure(n, rdy);
      chk(TAGS[i], n, VECS[i].lo, VECS[i].hi);
      chk("R11 vector ready", int'(clk_ready), 1, 1);
    end

    osc_mode = 3'd4;
    pwrt_en_n = 0;

    // R9: software sets the flag; pin and software resets leave it alone
    @(negedge clk_rc);
    sw_set_flag = 1;
    @(negedge clk_rc);
    sw_set_flag = 0;
    chk("R9 flag set by software", int'(por_flag_n), 1, 1);
    pulse_sw();
    measure(n, rdy);
    chk("R9 flag after sw reset", int'(por_flag_n), 1, 1);

    // R6: short pin pulse ignored
    @(negedge clk_rc);
    rst_pin_n = 0;
    repeat (2) @(negedge clk_rc);
    rst_pin_n = 1;
    hi_seen = 0;
    repeat (12) begin
      @(negedge clk_rc);
      if (core_rst) hi_seen = 1;
    end
    chk("R6 short pulse filtered", hi_seen, 0, 0);

    // R6: long pin hold resets; R9 flag unchanged
    rst_pin_n = 0;
    hi_seen = 0;
    repeat (12) begin
      @(negedge clk_rc);
      if (core_rst) hi_seen = 1;
    end
    rst_pin_n = 1;
    chk("R6 long hold resets", hi_seen, 1, 1);
    @(negedge clk_rc);
    measure(n, rdy);
    chk("R6 release after pin", int'(clk_ready), 1, 1);
    chk("R9 flag after pin reset", int'(por_flag_n), 1, 1);

    // R7: disabled pin has no effect
    pin_en = 0;
    @(negedge clk_rc);
    rst_pin_n = 0;
    hi_seen = 0;
    repeat (20) begin
      @(negedge clk_rc);
      if (core_rst || !clk_ready) hi_seen = 1;
    end
    rst_pin_n = 1;
    pin_en = 1;
    chk("R7 disabled pin ignored", hi_seen, 0, 0);
    repeat (4) @(negedge clk_rc);

    // R10: restart part way through the power-up timer
    pulse_sw();
    repeat (30) @(negedge clk_rc);
    chk("R10 mid-sequence reset", int'(core_rst), 1, 1);
    sw_reset = 1;
    @(negedge clk_rc);
    sw_reset = 0;
    measure(n, rdy);
    chk("R10 full restart length", n, T1, T1);

    // R9: power-on and software set in the same cycle, power-on wins
    @(negedge clk_rc);
    por_in = 1;
    sw_set_flag = 1;
    @(negedge clk_rc);
    por_in = 0;
    sw_set_flag = 0;
    chk("R9 same-cycle power-on wins", int'(por_flag_n), 0, 0);
    measure(n, rdy);
    chk("R1 flag stays cleared", int'(por_flag_n), 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule